// File: doc/BRIEF.md
# DDR2 Inter-Bank Command Spacing Monitor

A passive observer for a DDR2 command bus. Each clock it decodes the active-low chip-select, row-strobe, column-strobe and write-enable lines, together with the bank address and the A10 line. It keeps its own record of which banks hold an open row, and it raises a one-cycle violation flag with a code whenever the command stream breaks a spacing or legality rule. The rules it checks are the gap after a column command with auto-precharge when the next command goes to another bank, the quiet window after a mode-register write, mode-register writes while rows are open, reserved encodings, and burst interruptions that do not fall on a 4-bit boundary.

The monitor never drives the bus. It sits next to a memory controller in simulation or in silicon debug logic. Burst length, CAS latency, write-to-read turnaround and mode-register delay come in as runtime configuration. The monitor copies them only while no spacing window or quiet window is open, so a configuration change never alters a window that is already running. Refresh timing, same-bank timing and the data bus are not modelled.

Top module: `ddr2_apcmd_monitor`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, viol_pulse is 0 and viol_code is all zeros.
- R2: Commands are decoded from {cs_n, ras_n, cas_n, we_n}. Any word with cs_n=1 is deselect, and 0111 is no-operation. Neither of these is ever flagged. The other words are: 0011 activate, 0101 read, 0100 write, 0010 precharge (A10=1 closes all banks), 0001 refresh, 0000 mode-register write. On read and write, A10=1 requests auto-precharge.
- R3: A read, with or without auto-precharge, issued to a different bank fewer than BL/2 cycles after a read with auto-precharge is flagged with rule 4. A read to the same bank is not subject to this gap.
- R4: A write, with or without auto-precharge, issued to a different bank fewer than BL/2+2 cycles after a read with auto-precharge is flagged with rule 4.
- R5: A read issued to a different bank fewer than (CL−1)+BL/2+tWTR cycles after a write with auto-precharge is flagged with rule 4. CL=0 is treated as CL=1.
- R6: A write issued to a different bank fewer than BL/2 cycles after a write with auto-precharge is flagged with rule 4.
- R7: Activate or precharge to another bank one cycle or more after an auto-precharge column command is never flagged with rule 4.
- R8: A mode-register write issued while any bank has an open row is flagged with rule 3. Activate opens a bank. Precharge, precharge-all and auto-precharge column commands close banks.
- R9: For tMRD−1 cycles after a mode-register write, any command other than deselect or no-operation is flagged with rule 1. From tMRD cycles onward, commands are accepted again.
- R10: A read or write issued an odd number of cycles, and fewer than BL/2 cycles, after the previous read or write interrupts a burst off its 4-bit boundary and is flagged with rule 5.
- R11: The reserved word 0110 is flagged with rule 2.
- R12: cfg_bl8 (1 selects BL=8, 0 selects BL=4), cfg_cl, cfg_twtr and cfg_tmrd are copied only while no auto-precharge window and no mode-register window is open. A change during an open window does not affect that window.
- R13: A violation gives a one-cycle viol_pulse in the cycle after the command. viol_code is {rule[2:0], bank of the offending command}, and it is zero when no rule is broken. When several rules fail at once, the rule with the lowest number wins (1 first, then 2, 3, 4, 5). Monitoring continues normally afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (3) | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| cfg_bl8 | input | 1 | 1: burst length 8, 0: burst length 4 |
| cfg_cl | input | CFG_W (4) | CAS latency in clocks |
| cfg_twtr | input | CFG_W (4) | Write-to-read turnaround in clocks |
| cfg_tmrd | input | CFG_W (4) | Mode-register write delay in clocks |
| viol_pulse | output | 1 | One-cycle violation flag |
| viol_code | output | 3+BA_W (6) | {rule, bank}; zero when quiet |

## Verification
An elapsed counter that is off by one shows up at the ports as a flag at exactly the boundary gap: either a legal command at the minimum distance gets flagged, or one cycle short of it passes silently. For this reason every spacing rule is probed on both sides of its limit. A stale bank-open bit only becomes visible at the next mode-register write, which may be many cycles later. A configuration copy taken at the wrong moment changes the pass/fail boundary of the very next cross-bank column command. Any of these faults appears as a wrong flag or code one cycle after the offending command.

// File: rtl/ddr2mon_pkg.sv
package ddr2mon_pkg;

    typedef enum logic [3:0] {
        CMD_DESL,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_RSV
    } cmd_e;

    // lower value = higher priority when several rules fire together
    typedef enum logic [2:0] {
        RULE_NONE     = 3'd0,
        RULE_LOCK     = 3'd1,
        RULE_RSVD     = 3'd2,
        RULE_MRS_BUSY = 3'd3,
        RULE_AP_GAP   = 3'd4,
        RULE_BURST    = 3'd5
    } rule_e;

    localparam int RULE_W = 3;

endpackage

// File: rtl/ddr2mon_decode.sv
module ddr2mon_decode
    import ddr2mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_RSV;
            endcase
        end
    end

endmodule

// File: rtl/ddr2mon_bank_track.sv
module ddr2mon_bank_track
    import ddr2mon_pkg::*;
#(
    parameter int BANKS = 8,
    localparam int BA_W = $clog2(BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic            any_open
);

    logic [BANKS-1:0] open_d, open_q;

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        logic hit, nxt;
        assign hit = (ba == BA_W'(i));
        always_comb begin
            nxt = open_q[i];
            if (cmd == CMD_ACT && hit) begin
                nxt = 1'b1;
            end else if (cmd == CMD_PRE && (a10 || hit)) begin
                nxt = 1'b0;
            end else if ((cmd == CMD_RD || cmd == CMD_WR) && a10 && hit) begin
                nxt = 1'b0;
            end
        end
        assign open_d[i] = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= open_d;
    end

    assign any_open = |open_q;

endmodule

// File: rtl/ddr2mon_rules.sv
module ddr2mon_rules
    import ddr2mon_pkg::*;
#(
    parameter int BANKS = 8,
    parameter int CFG_W = 4,
    localparam int BA_W   = $clog2(BANKS),
    localparam int EL_W   = CFG_W + 2,
    localparam int CODE_W = RULE_W + BA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [BA_W-1:0]   ba,
    input  logic              a10,
    input  logic              any_open,
    input  logic              cfg_bl8,
    input  logic [CFG_W-1:0]  cfg_cl,
    input  logic [CFG_W-1:0]  cfg_twtr,
    input  logic [CFG_W-1:0]  cfg_tmrd,
    output logic              viol_pulse,
    output logic [CODE_W-1:0] viol_code
);

    typedef struct packed {
        logic              bl8;
        logic [CFG_W-1:0]  cl;
        logic [CFG_W-1:0]  twtr;
        logic [CFG_W-1:0]  tmrd;
        logic              ap_v;
        logic              ap_wr;
        logic [BA_W-1:0]   ap_bank;
        logic [EL_W-1:0]   ap_el;
        logic              col_v;
        logic [EL_W-1:0]   col_el;
        logic [CFG_W-1:0]  mrd;
        logic              viol;
        logic [CODE_W-1:0] code;
    } state_t;

    state_t s_d, s_q;

    logic [EL_W-1:0]  half, lim_rd_wr, lim_wr_rd, need, ap_end;
    logic [CFG_W-1:0] cl_m1;
    logic             is_col, locked;
    logic             lock_hit, rsv_hit, busy_hit, ap_hit, burst_hit;
    rule_e            rule;

    always_comb begin
        half      = s_q.bl8 ? EL_W'(4) : EL_W'(2);
        cl_m1     = (s_q.cl == '0) ? '0 : s_q.cl - 1'b1;
        lim_rd_wr = half + EL_W'(2);
        lim_wr_rd = EL_W'(cl_m1) + half + EL_W'(s_q.twtr);
        ap_end    = s_q.ap_wr ? lim_wr_rd : lim_rd_wr;
        is_col    = (cmd == CMD_RD) || (cmd == CMD_WR);
        locked    = (s_q.mrd != '0);

        if (s_q.ap_wr) need = (cmd == CMD_RD) ? lim_wr_rd : half;
        else           need = (cmd == CMD_RD) ? half : lim_rd_wr;

        lock_hit  = locked && (cmd != CMD_NOP) && (cmd != CMD_DESL);
        rsv_hit   = (cmd == CMD_RSV);
        busy_hit  = (cmd == CMD_MRS) && any_open;
        ap_hit    = s_q.ap_v && is_col && (ba != s_q.ap_bank) && (s_q.ap_el < need);
        burst_hit = s_q.col_v && is_col && (s_q.col_el < half) && s_q.col_el[0];

        if      (lock_hit)  rule = RULE_LOCK;
        else if (rsv_hit)   rule = RULE_RSVD;
        else if (busy_hit)  rule = RULE_MRS_BUSY;
        else if (ap_hit)    rule = RULE_AP_GAP;
        else if (burst_hit) rule = RULE_BURST;
        else                rule = RULE_NONE;

        s_d      = s_q;
        s_d.viol = (rule != RULE_NONE);
        s_d.code = (rule != RULE_NONE) ? {rule, ba} : '0;

        // configuration is copied only with no window open
        if (!s_q.ap_v && !locked) begin
            s_d.bl8  = cfg_bl8;
            s_d.cl   = cfg_cl;
            s_d.twtr = cfg_twtr;
            s_d.tmrd = cfg_tmrd;
        end

        // auto-precharge window
        if (is_col && a10) begin
            s_d.ap_v    = 1'b1;
            s_d.ap_wr   = (cmd == CMD_WR);
            s_d.ap_bank = ba;
            s_d.ap_el   = EL_W'(1);
        end else if (s_q.ap_v) begin
            if (s_q.ap_el >= ap_end) s_d.ap_v  = 1'b0;
            else                     s_d.ap_el = s_q.ap_el + 1'b1;
        end

        // burst window of the last column command
        if (is_col) begin
            s_d.col_v  = 1'b1;
            s_d.col_el = EL_W'(1);
        end else if (s_q.col_v) begin
            if (s_q.col_el >= half) s_d.col_v  = 1'b0;
            else                    s_d.col_el = s_q.col_el + 1'b1;
        end

        // mode-register quiet window
        if (cmd == CMD_MRS && !locked) begin
            s_d.mrd = (s_q.tmrd == '0) ? '0 : s_q.tmrd - 1'b1;
        end else if (locked) begin
            s_d.mrd = s_q.mrd - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.bl8  <= cfg_bl8;
            s_q.cl   <= cfg_cl;
            s_q.twtr <= cfg_twtr;
            s_q.tmrd <= cfg_tmrd;
        end else begin
            s_q <= s_d;
        end
    end

    assign viol_pulse = s_q.viol;
    assign viol_code  = s_q.code;

endmodule

// File: rtl/ddr2_apcmd_monitor.sv
module ddr2_apcmd_monitor
    import ddr2mon_pkg::*;
#(
    parameter int BANKS = 8,
    parameter int CFG_W = 4,
    localparam int BA_W   = $clog2(BANKS),
    localparam int CODE_W = RULE_W + BA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic              a10,
    input  logic              cfg_bl8,
    input  logic [CFG_W-1:0]  cfg_cl,
    input  logic [CFG_W-1:0]  cfg_twtr,
    input  logic [CFG_W-1:0]  cfg_tmrd,
    output logic              viol_pulse,
    output logic [CODE_W-1:0] viol_code
);

    cmd_e cmd;
    logic any_open;

    ddr2mon_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    ddr2mon_bank_track #(.BANKS(BANKS)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ba       (ba),
        .a10      (a10),
        .any_open (any_open)
    );

    ddr2mon_rules #(.BANKS(BANKS), .CFG_W(CFG_W)) u_rules (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .ba         (ba),
        .a10        (a10),
        .any_open   (any_open),
        .cfg_bl8    (cfg_bl8),
        .cfg_cl     (cfg_cl),
        .cfg_twtr   (cfg_twtr),
        .cfg_tmrd   (cfg_tmrd),
        .viol_pulse (viol_pulse),
        .viol_code  (viol_code)
    );

endmodule

// File: rtl/ddr2mon_checker.sv
module ddr2mon_checker #(
    parameter int BA_W   = 3,
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic              viol_pulse,
    input logic [CODE_W-1:0] viol_code
);

    logic [2:0] rule_f;
    assign rule_f = viol_code[CODE_W-1 -: 3];

    AST_QUIET_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_pulse |-> viol_code == '0); // R13

    AST_RULE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> (rule_f >= 3'd1 && rule_f <= 3'd5)); // R13

    AST_BANK_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> viol_code[BA_W-1:0] == $past(ba)); // R13

    AST_DESL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !viol_pulse); // R2

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ras_n && cas_n && we_n) |=> !viol_pulse); // R2

    AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ras_n && cas_n && !we_n) |=> viol_pulse); // R11

    AST_ROWCMD_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && cas_n) |=> rule_f != 3'd4); // R7

endmodule

bind ddr2_apcmd_monitor ddr2mon_checker #(.BA_W(BA_W), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .viol_pulse (viol_pulse),
    .viol_code  (viol_code)
);

// File: tb/tb_ddr2_apcmd_monitor.sv
module tb_ddr2_apcmd_monitor;

    localparam int BANKS  = 8;
    localparam int BA_W   = 3;
    localparam int CFG_W  = 4;
    localparam int CODE_W = 6;

    localparam logic [3:0] C_DESL = 4'b1111;
    localparam logic [3:0] C_NOP  = 4'b0111;
    localparam logic [3:0] C_ACT  = 4'b0011;
    localparam logic [3:0] C_RD   = 4'b0101;
    localparam logic [3:0] C_WR   = 4'b0100;
    localparam logic [3:0] C_PRE  = 4'b0010;
    localparam logic [3:0] C_MRS  = 4'b0000;
    localparam logic [3:0] C_RSV  = 4'b0110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BA_W-1:0] ba = '0;
    logic a10 = 1'b0;
    logic cfg_bl8 = 1'b1;
    logic [CFG_W-1:0] cfg_cl = 4'd3, cfg_twtr = 4'd2, cfg_tmrd = 4'd3;
    logic viol_pulse;
    logic [CODE_W-1:0] viol_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    ddr2_apcmd_monitor #(.BANKS(BANKS), .CFG_W(CFG_W)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .cfg_bl8(cfg_bl8), .cfg_cl(cfg_cl),
        .cfg_twtr(cfg_twtr), .cfg_tmrd(cfg_tmrd),
        .viol_pulse(viol_pulse), .viol_code(viol_code)
    );

    // first command, gap in cycles, second command, expected rule, requirement
    typedef struct packed {
        logic [3:0] c1; logic [2:0] b1; logic a1;
        logic [3:0] gap;
        logic [3:0] c2; logic [2:0] b2; logic a2;
        logic [2:0] rule;
        logic [3:0] req;
    } scen_t;

    // configuration: BL=8 (BL/2=4), CL=3, tWTR=2 -> write-AP to read needs 8
    localparam int NSCN = 16;
    localparam scen_t SCN [NSCN] = '{
        '{C_RD,  3'd0, 1'b1, 4'd3, C_RD,  3'd1, 1'b0, 3'd4, 4'd3},  // R3 short
        '{C_RD,  3'd0, 1'b1, 4'd4, C_RD,  3'd1, 1'b0, 3'd0, 4'd3},  // R3 at limit
        '{C_RD,  3'd0, 1'b1, 4'd5, C_WR,  3'd1, 1'b0, 3'd4, 4'd4},  // R4 short
        '{C_RD,  3'd0, 1'b1, 4'd6, C_WR,  3'd1, 1'b1, 3'd0, 4'd4},  // R4 at limit
        '{C_WR,  3'd0, 1'b1, 4'd7, C_RD,  3'd1, 1'b0, 3'd4, 4'd5},  // R5 short
        '{C_WR,  3'd0, 1'b1, 4'd8, C_RD,  3'd1, 1'b1, 3'd0, 4'd5},  // R5 at limit
        '{C_WR,  3'd0, 1'b1, 4'd2, C_WR,  3'd1, 1'b0, 3'd4, 4'd6},  // R6 short
        '{C_WR,  3'd0, 1'b1, 4'd4, C_WR,  3'd1, 1'b0, 3'd0, 4'd6},  // R6 at limit
        '{C_RD,  3'd0, 1'b1, 4'd1, C_ACT, 3'd1, 1'b0, 3'd0, 4'd7},  // R7 activate
        '{C_WR,  3'd0, 1'b1, 4'd1, C_PRE, 3'd1, 1'b0, 3'd0, 4'd7},  // R7 precharge
        '{C_RD,  3'd0, 1'b0, 4'd1, C_RD,  3'd1, 1'b0, 3'd5, 4'd10}, // R10 odd 1
        '{C_RD,  3'd0, 1'b0, 4'd3, C_WR,  3'd0, 1'b0, 3'd5, 4'd10}, // R10 odd 3
        '{C_RD,  3'd0, 1'b0, 4'd2, C_RD,  3'd3, 1'b0, 3'd0, 4'd10}, // R10 boundary
        '{C_RD,  3'd0, 1'b1, 4'd1, C_RD,  3'd1, 1'b0, 3'd4, 4'd13}, // R13 priority
        '{C_NOP, 3'd0, 1'b0, 4'd1, C_RSV, 3'd2, 1'b0, 3'd2, 4'd11}, // R11 reserved
        '{C_RD,  3'd0, 1'b1, 4'd2, C_RD,  3'd0, 1'b0, 3'd0, 4'd3}   // R3 same bank
    };

    task automatic check(input int rule, input int b, input string tag);
        logic exp_v;
        logic [CODE_W-1:0] exp_c;
        exp_v = (rule != 0);
        exp_c = exp_v ? {3'(rule), BA_W'(b)} : '0;
        checks++;
        if (viol_pulse !== exp_v || viol_code !== exp_c) begin
            fails++;
            $display("FAIL %s: viol=%0b code=%02h expected viol=%0b code=%02h",
                     tag, viol_pulse, viol_code, exp_v, exp_c);
        end
    endtask

    task automatic step(input logic [3:0] c, input int b, input logic a,
                        input int rule, input string tag);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba  = BA_W'(b);
        a10 = a;
        @(posedge clk);
        #2;
        check(rule, b, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) step(C_NOP, 0, 1'b0, 0, "R2 idle nop");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs quiet even with a reserved word on the bus
        {cs_n, ras_n, cas_n, we_n} = C_RSV;
        repeat (3) @(posedge clk);
        #2;
        check(0, 0, "R1 in reset");
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check(0, 0, "R1 first cycle after reset");

        // R2: deselect with any strobe pattern never flags
        step(C_DESL, 0, 1'b0, 0, "R2 deselect");
        step(4'b1000, 5, 1'b1, 0, "R2 deselect low strobes");
        step(C_NOP, 7, 1'b1, 0, "R2 nop");

        // table of two-command scenarios
        for (int i = 0; i < NSCN; i++) begin
            idle(12);
            step(SCN[i].c1, int'(SCN[i].b1), SCN[i].a1, 0,
                 $sformatf("R%0d scenario %0d first", SCN[i].req, i));
            for (int g = 1; g < int'(SCN[i].gap); g++)
                step(C_NOP, 0, 1'b0, 0, $sformatf("R%0d scenario %0d gap", SCN[i].req, i));
            step(SCN[i].c2, int'(SCN[i].b2), SCN[i].a2, int'(SCN[i].rule),
                 $sformatf("R%0d scenario %0d second", SCN[i].req, i));
        end

        // R8 / R9: mode-register window and open-bank rule, tMRD=3
        idle(12);
        step(C_PRE, 0, 1'b1, 0, "R8 precharge all");
        step(C_MRS, 0, 1'b0, 0, "R8 mode write all idle");
        step(C_NOP, 0, 1'b0, 0, "R9 nop in window");
        step(C_ACT, 2, 1'b0, 1, "R9 activate inside window");
        step(C_ACT, 3, 1'b0, 0, "R9 activate at tMRD");
        step(C_MRS, 1, 1'b0, 3, "R8 mode write with open banks");
        step(C_NOP, 0, 1'b0, 0, "R9 nop in window");
        step(C_RSV, 4, 1'b0, 1, "R13 lock beats reserved");
        step(C_PRE, 2, 1'b0, 0, "R8 close bank 2");
        step(C_PRE, 3, 1'b0, 0, "R8 close bank 3");
        step(C_MRS, 2, 1'b0, 0, "R8 mode write after closes");
        idle(2);
        step(C_ACT, 1, 1'b0, 0, "R8 open bank 1");
        step(C_RD, 1, 1'b1, 0, "R8 auto-precharge closes bank 1");
        idle(12);
        step(C_MRS, 0, 1'b0, 0, "R8 mode write after auto-precharge");
        idle(2);

        // R12: configuration frozen during an open window
        idle(12);
        step(C_RD, 0, 1'b1, 0, "R12 read-AP under BL8");
        cfg_bl8 = 1'b0;
        step(C_NOP, 0, 1'b0, 0, "R12 gap");
        step(C_NOP, 0, 1'b0, 0, "R12 gap");
        step(C_RD, 1, 1'b0, 4, "R12 BL8 still applies in open window");
        idle(12);
        step(C_RD, 0, 1'b1, 0, "R12 read-AP under BL4");
        step(C_NOP, 0, 1'b0, 0, "R12 gap");
        step(C_RD, 1, 1'b0, 0, "R12 BL4 limit of 2 met");
        idle(12);
        step(C_RD, 0, 1'b0, 0, "R10 read under BL4");
        step(C_WR, 2, 1'b0, 5, "R10 BL4 interrupt at 1");
        step(C_NOP, 0, 1'b0, 0, "R13 monitoring continues");

        done = 1;
        summary();
        $finish;
    end

endmodule